// File: doc/BRIEF.md
# Byte-Table Population Counter

This block returns how many bits are set in a 32-bit input word. It keeps a 256-entry table of per-byte bit counts. After reset the table is empty, so the block builds it first: the entry for each byte value is the entry for that value shifted right by one, plus the value's lowest bit. Entries are written one per cycle in rising order, so the entry a write depends on is always already present. `ready_o` stays low while this build runs.

Once the table is built, each word presented with `valid_i` is cut into four byte lanes. Each lane addresses its own read port of the table, and the four lane counts are added. The 6-bit total is registered, and it appears with `valid_o` one cycle after the word is accepted. Words may arrive on every cycle. When no word is accepted, `count_o` keeps its last value.

Top module: `popcnt_bytetab`

## Requirements
- R1: While `rst_ni` is low, `ready_o` and `valid_o` are 0 and `count_o` is 0.
- R2: `ready_o` goes high at the 256th rising clock edge after reset is released and not earlier. That edge writes table entry 255.
- R3: A `valid_i` sampled while `ready_o` is low is ignored. It produces no `valid_o` pulse and does not change `count_o`.
- R4: A word accepted at a rising edge (`valid_i` and `ready_o` both high before the edge) raises `valid_o` after that same edge, so the result is visible one cycle later.
- R5: The table holds the bit count of each byte value: entry 0 holds 0, and entry i holds entry (i>>1) plus bit 0 of i. The result is therefore the number of 1 bits among `data_i[31:0]`.
- R6: The two extreme words are counted correctly: 0x00000000 gives 0 and 0xFFFFFFFF gives 32. `count_o` is unsigned and 6 bits wide, with bit 0 as the LSB.
- R7: In a cycle after an edge that accepted no word, `valid_o` is 0 and `count_o` holds the previous result.
- R8: Words accepted on consecutive edges each produce their own result on consecutive cycles.
- R9: Once high, `ready_o` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is present |
| data_i | input | 32 | Word to be counted |
| ready_o | output | 1 | Table is built and words are accepted |
| valid_o | output | 1 | `count_o` carries a new result |
| count_o | output | 6 | Number of set bits in the accepted word |

## Verification
The write of the last table entry and the first offered word can fall on the same edge. Table writes and lookups share the same storage. The bench holds `valid_i` high with an all-ones word through the whole build, including the edge that writes entry 255. It then checks that `valid_o` stayed low and that `ready_o` rose at exactly that edge. Right after that edge, a sweep of every byte value copied into all four lanes reads each entry through each port. The sweep shows that no entry, including the last one written, was missed or read stale.

// File: rtl/pop_pkg.sv
package pop_pkg;
  typedef enum logic {
    ST_FILL = 1'b0,
    ST_RUN  = 1'b1
  } fill_st_e;
endpackage

// File: rtl/pop_fill_ctrl.sv
module pop_fill_ctrl
  import pop_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DEPTH = 1 << BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic              ready_o
);
  fill_st_e          st_q;
  logic [BYTE_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FILL;
      idx_q <= '0;
    end else if (st_q == ST_FILL) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == BYTE_W'(DEPTH - 1)) st_q <= ST_RUN;
    end
  end

  assign wr_en_o   = (st_q == ST_FILL);
  assign wr_addr_o = idx_q;
  assign ready_o   = (st_q == ST_RUN);
endmodule

// File: rtl/pop_table.sv
module pop_table #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DEPTH = 1 << BYTE_W,
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic                         clk_i,
  input  logic                         wr_en_i,
  input  logic [BYTE_W-1:0]            wr_addr_i,
  input  logic [LANES*BYTE_W-1:0]      rd_word_i,
  output logic [LANES-1:0][CNT_W-1:0]  rd_cnt_o
);
  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] wr_data;

  // entry(i) = entry(i>>1) + lsb(i); the source entry was written on an earlier cycle
  always_comb begin
    if (wr_addr_i == '0) wr_data = '0;
    else                 wr_data = mem[wr_addr_i >> 1] + CNT_W'(wr_addr_i[0]);
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rd_cnt_o[l] = mem[rd_word_i[l*BYTE_W +: BYTE_W]];
  end
endmodule

// File: rtl/pop_sum.sv
module pop_sum #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1),
  localparam int unsigned SUM_W = $clog2(LANES * BYTE_W + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        take_i,
  input  logic [LANES-1:0][CNT_W-1:0] lane_cnt_i,
  output logic                        valid_o,
  output logic [SUM_W-1:0]            sum_o
);
  logic [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int l = 0; l < LANES; l++) acc = acc + SUM_W'(lane_cnt_i[l]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      valid_o <= take_i;
      if (take_i) sum_o <= acc;
    end
  end
endmodule

// File: rtl/popcnt_bytetab.sv
module popcnt_bytetab #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1),
  localparam int unsigned SUM_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              valid_o,
  output logic [SUM_W-1:0]  count_o
);
  logic                        wr_en;
  logic [BYTE_W-1:0]           wr_addr;
  logic [LANES-1:0][CNT_W-1:0] lane_cnt;

  pop_fill_ctrl #(.BYTE_W(BYTE_W)) u_fill (
    .clk_i, .rst_ni,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .ready_o(ready_o)
  );

  pop_table #(.BYTE_W(BYTE_W), .LANES(LANES)) u_tab (
    .clk_i,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .rd_word_i(data_i), .rd_cnt_o(lane_cnt)
  );

  pop_sum #(.BYTE_W(BYTE_W), .LANES(LANES)) u_sum (
    .clk_i, .rst_ni,
    .take_i(valid_i && ready_o),
    .lane_cnt_i(lane_cnt),
    .valid_o(valid_o), .sum_o(count_o)
  );
endmodule

// File: rtl/pop_chk.sv
module pop_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DEPTH = 1 << BYTE_W,
  localparam int unsigned SUM_W = $clog2(DATA_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              ready_o,
  input logic              valid_o,
  input logic [SUM_W-1:0]  count_o
);
  logic [BYTE_W:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cyc_q <= '0;
    else if (cyc_q != (BYTE_W+1)'(DEPTH)) cyc_q <= cyc_q + 1'b1;
  end

  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!ready_o && !valid_o && count_o == '0);
  end

  a_r2_ready_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == (cyc_q == (BYTE_W+1)'(DEPTH)));

  a_r3_no_out_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> !valid_o);

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> valid_o);

  a_r5_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (count_o == SUM_W'($countones($past(data_i)))));

  a_r6_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= SUM_W'(DATA_W));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ready_o) |=> (!valid_o && $stable(count_o)));

  a_r9_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

bind popcnt_bytetab pop_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/popcnt_bytetab_tb.sv
module popcnt_bytetab_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        ready_o, valid_o;
  logic [5:0]  count_o;

  int total = 0;
  int bad = 0;
  int last_cnt = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  popcnt_bytetab u_dut (.*);

  function automatic int ref_pc(input logic [31:0] d);
    int n = 0;
    for (int b = 0; b < 32; b++) n += int'(d[b]);
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, check result one cycle later at next negedge
  task automatic drive(input bit v, input logic [31:0] d, input string req);
    valid_i = v;
    data_i  = d;
    @(negedge clk_i);
    check({req, " valid_o"}, int'(valid_o), int'(v));
    if (v) last_cnt = ref_pc(d);
    check({req, " count_o"}, int'(count_o), last_cnt);
    check("R9 ready held", int'(ready_o), 1);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    // R1
    valid_i = 1'b1;
    data_i  = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    check("R1 ready_o", int'(ready_o), 0);
    check("R1 valid_o", int'(valid_o), 0);
    check("R1 count_o", int'(count_o), 0);
    rst_ni = 1'b1;
    // R2/R3: valid held high through build, incl. the edge writing entry 255
    for (int k = 1; k <= 256; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (valid_o) check("R3 no valid_o during build", 1, 0);
      if (count_o != 0) check("R3 count_o untouched", int'(count_o), 0);
      if (k == 255) check("R2 ready low at edge 255", int'(ready_o), 0);
    end
    check("R2 ready high at edge 256", int'(ready_o), 1);
    check("R3 ignored word gave no output", int'(valid_o), 0);
    last_cnt = 0;
    // R6 extremes
    drive(1'b1, 32'h0000_0000, "R6 zero");
    drive(1'b1, 32'hFFFF_FFFF, "R6 all ones");
    drive(1'b1, 32'h8000_0001, "R5 edge bits");
    drive(1'b0, 32'h1234_5678, "R7 idle hold");
    drive(1'b0, 32'hFFFF_FFFF, "R7 idle hold");
    drive(1'b1, 32'hFF00_FF00, "R4 lane mix");
    // R5: every byte value in every lane, back to back (R8)
    for (int b = 0; b < 256; b++) begin
      logic [7:0] by = 8'(b);
      drive(1'b1, {by, by, by, by}, "R5 table entry sweep");
    end
    for (int b = 0; b < 256; b++) begin
      logic [7:0] by = 8'(b);
      drive(1'b1, {8'h00, by, 8'hFF, ~by}, "R8 back-to-back lanes");
    end
    // random mix of valid and idle
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom % 4) != 0;
      logic [31:0] d = $urandom;
      drive(v, d, v ? "R4 random word" : "R7 random idle");
    end
    drive(1'b1, 32'hFFFF_FFFF, "R6 all ones tail");
    drive(1'b0, 32'h0, "R7 final hold");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule